// File: doc/BRIEF.md
# Immediate-Transfer and Branch Decoder

This block sits after instruction fetch in a small 16-bit processor and handles the instruction group whose top nibble is 2. Every instruction in the group is a pair of words: an opcode word that splits into four nibbles (group, operation/condition, operand register, destination), and a second word carrying an immediate value or a jump target. The block looks at the destination nibble. When it names the program counter (code 1), the instruction is a branch. An operation nibble of zero makes it unconditional. Any other value selects one of fifteen flag tests. When the destination is any other register, the instruction is an immediate ALU request, and the operation nibble is passed on as the ALU operation code.

The condition test uses an 8-bit flag vector. Odd condition codes check that a flag is set and even codes check that it is clear. Each adjacent odd/even pair shares one flag. The low four flags mean zero, negative, carry and overflow. The upper four flags have no producer yet, but they are tested exactly like the low ones, so branches on them really jump. The results are registered and appear as single-cycle strobes one clock after the instruction strobe. The fetch logic uses a not-taken strobe to step the program counter past both words of the instruction.

Top module: `imm_branch_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the strobes pc_load, br_skip and alu_req are all low.
- R2: An opcode word whose top nibble [15:12] is not 2, or any cycle with instr_valid low, raises no strobe in the following cycle.
- R3: With destination nibble [3:0] equal to 1 and operation nibble [11:8] equal to 0, pc_load rises one cycle later and pc_target equals the immediate word. This holds for any flag value (for example opcode 0x2031).
- R4: With destination 1 and an odd operation nibble c, the branch is taken exactly when flags[(c-1)/2] is 1.
- R5: With destination 1 and an even, non-zero operation nibble c, the branch is taken exactly when flags[(c-2)/2] is 0. For example, 0x2231 with immediate 0x03FF jumps to 0x03FF when flags[0] is 0.
- R6: Codes 9 to 15 test flags[4] to flags[7] with no special casing. With all flags 0, 0x2A31 followed by 0x03FF loads 0x03FF.
- R7: When a branch condition is false, pc_load stays low and br_skip pulses high one cycle after the strobe.
- R8: When the destination nibble is not 1, alu_req pulses one cycle later. It carries alu_op = bits [11:8], alu_src = bits [7:4], alu_dst = bits [3:0] and alu_imm = the immediate word. Operation code 0 is a plain move, and no branch strobe rises whatever the flags are.
- R9: The strobes last one cycle. Each is high only in the cycle that follows an accepted instruction.
- R10: At most one of pc_load, br_skip and alu_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Opcode and immediate words are present this cycle |
| instr_word | input | 16 | Opcode word |
| imm_word | input | IMM_W | Immediate value or jump target |
| flags | input | 8 | Condition flags, bit 0 upward: zero, negative, carry, overflow, four reserved |
| pc_load | output | 1 | Load program counter with pc_target |
| pc_target | output | IMM_W | Branch target |
| br_skip | output | 1 | Branch not taken; advance past both words |
| alu_req | output | 1 | Immediate ALU request |
| alu_op | output | 4 | ALU operation code |
| alu_src | output | 4 | Operand register field |
| alu_dst | output | 4 | Destination register field |
| alu_imm | output | IMM_W | Immediate operand |

## Verification
The bench builds the block with its default immediate width of 16. At this width the targets named in the requirements, such as 0x03FF, pass through unchanged, and random immediates cover the whole address range. Only 16 condition codes and 8 flags exist, so a few thousand random opcodes with random flag vectors reach every code against both values of its flag many times. Directed cases pin the unconditional jump, the reserved-flag jump after a zeroed flag vector, and foreign group nibbles.

// File: rtl/imm_branch_decoder.sv
module imm_branch_decoder #(
  parameter int IMM_W = 16,
  parameter logic [3:0] GROUP_ID = 4'd2,
  parameter logic [3:0] PC_DEST = 4'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [15:0]      instr_word,
  input  logic [IMM_W-1:0] imm_word,
  input  logic [7:0]       flags,
  output logic             pc_load,
  output logic [IMM_W-1:0] pc_target,
  output logic             br_skip,
  output logic             alu_req,
  output logic [3:0]       alu_op,
  output logic [3:0]       alu_src,
  output logic [3:0]       alu_dst,
  output logic [IMM_W-1:0] alu_imm
);
  logic [3:0] grp, cnd, opr, dst;
  assign {grp, cnd, opr, dst} = instr_word;

  logic       mine, to_pc;
  logic [2:0] fidx;
  logic       fsel, cond_ok;

  assign mine  = instr_valid && (grp == GROUP_ID);
  assign to_pc = (dst == PC_DEST);
  // odd code c tests bit (c-1)/2 set, even code tests bit (c-2)/2 clear
  assign fidx  = cnd[0] ? cnd[3:1] : cnd[3:1] - 3'd1;
  assign fsel  = flags[fidx];
  assign cond_ok = (cnd == 4'd0) ? 1'b1 : (cnd[0] ? fsel : ~fsel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load <= 1'b0;
      br_skip <= 1'b0;
      alu_req <= 1'b0;
    end else begin
      pc_load <= mine && to_pc && cond_ok;
      br_skip <= mine && to_pc && !cond_ok;
      alu_req <= mine && !to_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (mine && to_pc) pc_target <= imm_word;
    if (mine && !to_pc) begin
      alu_op  <= cnd;
      alu_src <= opr;
      alu_dst <= dst;
      alu_imm <= imm_word;
    end
  end
endmodule

// File: rtl/imm_branch_decoder_chk.sv
module imm_branch_decoder_chk #(
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [15:0]      instr_word,
  input logic [IMM_W-1:0] imm_word,
  input logic [7:0]       flags,
  input logic             pc_load,
  input logic [IMM_W-1:0] pc_target,
  input logic             br_skip,
  input logic             alu_req,
  input logic [3:0]       alu_op,
  input logic [3:0]       alu_src,
  input logic [3:0]       alu_dst,
  input logic [IMM_W-1:0] alu_imm
);
  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, br_skip, alu_req}));

  // R2
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid || instr_word[15:12] != 4'd2) |=> !(pc_load || br_skip || alu_req));

  // R3
  uncond_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_word[15:8] == 8'h20 && instr_word[3:0] == 4'd1)
      |=> (pc_load && pc_target == $past(imm_word)));

  // R8
  alu_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_word[15:12] == 4'd2 && instr_word[3:0] != 4'd1)
      |=> (alu_req && alu_op == $past(instr_word[11:8]) && alu_dst == $past(instr_word[3:0])
           && alu_src == $past(instr_word[7:4]) && alu_imm == $past(imm_word)));

  // R7
  skip_is_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_skip |-> $past(instr_valid && instr_word[15:12] == 4'd2 && instr_word[3:0] == 4'd1
                      && instr_word[11:8] != 4'd0));

  // R6
  reserved_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_word == 16'h2A31 && !flags[4]) |=> pc_load);
endmodule

bind imm_branch_decoder imm_branch_decoder_chk #(.IMM_W(IMM_W)) chk_i (.*);

// File: tb/imm_branch_decoder_tb_top.sv
module imm_branch_decoder_tb_top;
  localparam int IMM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [IMM_W-1:0] imm_word = '0;
  logic [7:0] flags = '0;
  logic pc_load, br_skip, alu_req;
  logic [IMM_W-1:0] pc_target, alu_imm;
  logic [3:0] alu_op, alu_src, alu_dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  imm_branch_decoder #(.IMM_W(IMM_W)) dut_i (.*);

  function automatic bit taken(input logic [3:0] c, input logic [7:0] f);
    if (c == 0) return 1'b1;
    if (c % 2 == 1) return f[(c - 1) / 2] == 1'b1;
    return f[(c - 2) / 2] == 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [15:0] w, input logic [15:0] im,
                       input logic [7:0] f);
    logic [3:0] c;
    string tag;
    instr_valid = v; instr_word = w; imm_word = im; flags = f;
    @(negedge clk);
    instr_valid = 1'b0;
    c = w[11:8];
    if (!v || w[15:12] != 4'd2) begin
      chk("R2", "strobes", {pc_load, br_skip, alu_req}, 0);
    end else if (w[3:0] == 4'd1) begin
      if (c == 0) tag = "R3";
      else if (c >= 9) tag = "R6";
      else if (c[0]) tag = "R4";
      else tag = "R5";
      chk(tag, "pc_load", pc_load, taken(c, f));
      chk("R7", "br_skip", br_skip, !taken(c, f));
      chk("R10", "alu_req", alu_req, 0);
      if (taken(c, f)) chk(tag, "pc_target", pc_target, im);
    end else begin
      chk("R8", "alu_req", alu_req, 1);
      chk("R8", "no branch", {pc_load, br_skip}, 0);
      chk("R8", "alu_op", alu_op, c);
      chk("R8", "alu_src", alu_src, w[7:4]);
      chk("R8", "alu_dst", alu_dst, w[3:0]);
      chk("R8", "alu_imm", alu_imm, im);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {pc_load, br_skip, alu_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes after reset", {pc_load, br_skip, alu_req}, 0);

    issue(1, 16'h2031, 16'h1234, 8'hFF);
    issue(1, 16'h2231, 16'h03FF, 8'h00);
    issue(1, 16'h2231, 16'h03FF, 8'h01);
    issue(1, 16'h2A31, 16'h03FF, 8'h00);
    issue(1, 16'h2F31, 16'hBEEF, 8'h80);
    issue(1, 16'h2F31, 16'hBEEF, 8'h7F);
    issue(1, 16'h2E31, 16'h0042, 8'h40);
    issue(1, 16'h3031, 16'h5555, 8'h00);
    issue(0, 16'h2031, 16'h5555, 8'h00);
    issue(1, 16'h2535, 16'hA5A5, 8'hFF);
    issue(1, 16'h2007, 16'h00FF, 8'h00);
    // R9: strobe does not persist once instr_valid drops
    @(negedge clk);
    chk("R9", "strobes idle", {pc_load, br_skip, alu_req}, 0);

    process::self().srandom(32'd20240611);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:12] = 4'd2;
      if ($urandom % 2 == 0) w[3:0] = 4'd1;
      issue(($urandom % 8) != 0, w, 16'($urandom), 8'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule